// File: doc/BRIEF.md
# Converter Trigger and Result Register Block

This block gives a host CPU an 8-bit register view of an external successive-approximation converter. The host starts a conversion by writing a channel number. There is no separate start command. The block stores the number, raises a busy flag, sends a one-cycle start pulse with the channel to the converter, and waits for the converter's done strobe. On that strobe it captures the whole result in one register.

Software polls one byte that carries the busy flag in its top bit and the upper result bits below it. One read therefore returns both status and high data. A second read returns the low eight result bits. Two static mode inputs select 10-bit or 11-bit resolution and straight-binary or two's complement format. The bits of the status byte that carry no result are driven with zeros, or with copies of the sign bit in two's complement mode. Software can therefore use the byte without masking.

Register addresses: 0 is the channel register (write starts a conversion, read returns the channel), 1 is the status/high byte, 2 is the low byte and 3 is unused.

Top module: `adcif_regs`

## Requirements
- R1: A synchronous reset clears busy, the channel register and the stored result. After reset, addresses 0, 1 and 2 read 0x00 and `conv_start` is low.
- R2: A write to address 0 while not busy has three effects. It stores `wdata` as the channel. It sets busy (bit 7 of address 1) after that clock edge. It pulses `conv_start` high for exactly the one cycle after the write, with `conv_chan` equal to the new channel.
- R3: While busy, a high `conv_done` at a clock edge clears busy at that edge. At the same edge it loads `conv_result` into the stored result, so the high and low bytes both show the new value as soon as busy reads 0.
- R4: A write to address 0 while busy is ignored. The channel readback and `conv_chan` keep their value, and no `conv_start` pulse follows.
- R5: In 11-bit mode (`res_11b`=1), address 1 bits 2..0 return result bits 10..8, and address 2 returns result bits 7..0.
- R6: In 10-bit mode (`res_11b`=0), address 1 bits 1..0 return result bits 9..8, and address 2 returns result bits 7..0. Result bit 10 has no effect on either byte.
- R7: In straight-binary mode (`twos_comp`=0), address 1 bits 6..3 (11-bit mode) or bits 6..2 (10-bit mode) read 0.
- R8: In two's complement mode (`twos_comp`=1), those same unused bits read as copies of the sign bit. The sign bit is result bit 10 in 11-bit mode and result bit 9 in 10-bit mode.
- R9: A `conv_done` that arrives while not busy is ignored, and the stored result keeps its value.
- R10: Address 3 reads 0x00. Address 0 reads back the stored channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| res_11b | input | 1 | 1 selects 11-bit resolution, 0 selects 10-bit |
| twos_comp | input | 1 | 1 selects two's complement formatting |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_chan | output | CHAN_W | Channel for the converter |
| conv_done | input | 1 | Converter completion strobe |
| conv_result | input | 11 | Converter parallel result |

## Verification
A busy flag stuck at 1 shows up on the next status read as a conversion that never ends. A busy flag that clears early shows up as a status read with busy at 0 while the high and low bytes still hold the previous result. Both are visible one cycle after the edge at fault. A trigger accepted while busy shows up at once as a changed channel readback or a second start pulse. Formatting faults appear only in specific mode and sign combinations. The bench therefore drives results with the sign bit set and clear, in every mode pair. It also includes one 10-bit case in which result bit 10 differs from bit 9.

// File: rtl/adcif_pkg.sv
package adcif_pkg;

    localparam int DATA_W = 8;
    localparam int RES_W  = 11;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CHAN = 2'd0,
        SEL_HIGH = 2'd1,
        SEL_LOW  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       busy;
        logic [6:0] upper;
    } high_byte_t;

    typedef struct packed {
        logic       wide;     // 11-bit resolution
        logic       signed_q; // two's complement formatting
    } fmt_mode_t;

    // Upper seven bits of the status byte for a stored result.
    function automatic logic [6:0] upper_bits(input logic [RES_W-1:0] r,
                                              input fmt_mode_t m);
        logic fill;
        logic [6:0] u;
        if (m.wide) begin
            fill = m.signed_q & r[10];
            u    = {{4{fill}}, r[10:8]};
        end else begin
            fill = m.signed_q & r[9];
            u    = {{5{fill}}, r[9:8]};
        end
        return u;
    endfunction

endpackage

// File: rtl/adcif_ctrl.sv
module adcif_ctrl
    import adcif_pkg::*;
#(
    parameter int CHAN_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_req,
    input  logic [CHAN_W-1:0] chan_in,
    input  logic              done_in,
    input  logic [RES_W-1:0]  result_in,
    output logic              busy_o,
    output logic              start_o,
    output logic [CHAN_W-1:0] chan_o,
    output logic [RES_W-1:0]  result_o
);

    logic accept;
    logic finish;

    assign accept = trig_req & ~busy_o;
    assign finish = busy_o & done_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o   <= 1'b0;
            start_o  <= 1'b0;
            chan_o   <= '0;
            result_o <= '0;
        end else begin
            start_o <= accept;
            if (accept) begin
                chan_o <= chan_in;
                busy_o <= 1'b1;
            end else if (finish) begin
                busy_o   <= 1'b0;
                result_o <= result_in;
            end
        end
    end

endmodule

// File: rtl/adcif_fmt.sv
module adcif_fmt
    import adcif_pkg::*;
(
    input  logic [RES_W-1:0]  result,
    input  fmt_mode_t         mode,
    input  logic              busy,
    output high_byte_t        high_o,
    output logic [DATA_W-1:0] low_o
);

    always_comb begin
        high_o.busy  = busy;
        high_o.upper = upper_bits(result, mode);
        low_o        = result[DATA_W-1:0];
    end

endmodule

// File: rtl/adcif_rdmux.sv
module adcif_rdmux
    import adcif_pkg::*;
#(
    parameter int CHAN_W = 8
) (
    input  reg_sel_e          sel,
    input  logic [CHAN_W-1:0] chan,
    input  high_byte_t        high_b,
    input  logic [DATA_W-1:0] low_b,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        unique case (sel)
            SEL_CHAN: rdata = DATA_W'(chan);
            SEL_HIGH: rdata = high_b;
            SEL_LOW:  rdata = low_b;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/adcif_regs.sv
module adcif_regs
    import adcif_pkg::*;
#(
    parameter int CHAN_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              res_11b,
    input  logic              twos_comp,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    input  logic              conv_done,
    input  logic [10:0]       conv_result
);

    reg_sel_e          sel;
    fmt_mode_t         mode;
    logic              trig_w;
    logic              busy_w;
    logic [RES_W-1:0]  res_w;
    high_byte_t        high_w;
    logic [DATA_W-1:0] low_w;

    assign sel    = reg_sel_e'(addr);
    assign mode   = '{wide: res_11b, signed_q: twos_comp};
    assign trig_w = wr_en & (sel == SEL_CHAN);

    adcif_ctrl #(.CHAN_W(CHAN_W)) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .trig_req (trig_w),
        .chan_in  (wdata[CHAN_W-1:0]),
        .done_in  (conv_done),
        .result_in(conv_result),
        .busy_o   (busy_w),
        .start_o  (conv_start),
        .chan_o   (conv_chan),
        .result_o (res_w)
    );

    adcif_fmt fmt_i (
        .result(res_w),
        .mode  (mode),
        .busy  (busy_w),
        .high_o(high_w),
        .low_o (low_w)
    );

    adcif_rdmux #(.CHAN_W(CHAN_W)) mux_i (
        .sel   (sel),
        .chan  (conv_chan),
        .high_b(high_w),
        .low_b (low_w),
        .rdata (rdata)
    );

endmodule

// File: rtl/adcif_regs_chk.sv
module adcif_regs_chk #(
    parameter int CHAN_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        addr,
    input logic              conv_done,
    input logic              conv_start,
    input logic [CHAN_W-1:0] conv_chan,
    input logic              busy,
    input logic [10:0]       res
);

    logic trig;
    assign trig = wr_en && (addr == 2'd0);

    assert_busy_set_R2: assert property (@(posedge clk) disable iff (rst)
        (trig && !busy) |=> (busy && conv_start));

    assert_start_single_R2: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    assert_start_in_busy_R2: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> busy);

    assert_busy_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && conv_done) |=> !busy);

    assert_trig_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (trig && busy) |=> ($stable(conv_chan) && !conv_start));

    assert_idle_done_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && conv_done) |=> $stable(res));

endmodule

bind adcif_regs adcif_regs_chk #(.CHAN_W(CHAN_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .conv_done (conv_done),
    .conv_start(conv_start),
    .conv_chan (conv_chan),
    .busy      (busy_w),
    .res       (res_w)
);

// File: tb/adcif_regs_tb_top.sv
module adcif_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  addr;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic        res_11b;
    logic        twos_comp;
    logic        conv_start;
    logic [7:0]  conv_chan;
    logic        conv_done;
    logic [10:0] conv_result;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    adcif_regs #(.CHAN_W(8)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .res_11b(res_11b), .twos_comp(twos_comp),
        .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_done(conv_done), .conv_result(conv_result)
    );

    // {wide, twos, chan[3:0], result[10:0], exp_upper[6:0], exp_low[7:0]}
    localparam int NV = 9;
    localparam logic [31:0] VEC [NV] = '{
        {1'b1, 1'b0, 4'd3,  11'h5A3, 7'h05, 8'hA3},
        {1'b1, 1'b1, 4'd4,  11'h5A3, 7'h7D, 8'hA3},
        {1'b1, 1'b1, 4'd5,  11'h2FF, 7'h02, 8'hFF},
        {1'b0, 1'b0, 4'd6,  11'h7C1, 7'h03, 8'hC1},
        {1'b0, 1'b1, 4'd7,  11'h7C1, 7'h7F, 8'hC1},
        {1'b0, 1'b1, 4'd8,  11'h4C1, 7'h00, 8'hC1},
        {1'b1, 1'b0, 4'd9,  11'h7FF, 7'h07, 8'hFF},
        {1'b0, 1'b0, 4'd10, 11'h000, 7'h00, 8'h00},
        {1'b1, 1'b1, 4'd15, 11'h400, 7'h7C, 8'h00}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic trigger(input logic [7:0] ch);
        addr  = 2'd0;
        wdata = ch;
        wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic finish_done(input logic [10:0] r);
        conv_result = r;
        conv_done   = 1'b1;
        tick();
        conv_done   = 1'b0;
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        logic [7:0] d;
        logic [31:0] v;
        rst = 1'b1; wr_en = 1'b0; addr = 2'd0; wdata = 8'h00;
        res_11b = 1'b1; twos_comp = 1'b0; conv_done = 1'b0;
        conv_result = 11'h000;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1: reset state
        rd(2'd0, d); check("R1 chan", d, 8'h00);
        rd(2'd1, d); check("R1 high", d, 8'h00);
        rd(2'd2, d); check("R1 low", d, 8'h00);
        check("R1 start", conv_start, 1'b0);
        // R10: unused address
        rd(2'd3, d); check("R10 addr3", d, 8'h00);

        // Vector table: R2, R3, R5, R6, R7, R8, R10
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            res_11b   = v[31];
            twos_comp = v[30];
            trigger({4'h0, v[29:26]});
            check("R2 start pulse", conv_start, 1'b1);
            check("R2 conv_chan", conv_chan, {4'h0, v[29:26]});
            rd(2'd1, d); check("R2 busy set", d[7], 1'b1);
            tick();
            check("R2 start single", conv_start, 1'b0);
            repeat (3) tick();
            rd(2'd1, d); check("R3 still busy", d[7], 1'b1);
            finish_done(v[25:15]);
            rd(2'd1, d); check("R3 R5 R6 R7 R8 high byte", d, {1'b0, v[14:8]});
            rd(2'd2, d); check("R3 R5 R6 low byte", d, v[7:0]);
            rd(2'd0, d); check("R10 chan readback", d, {4'h0, v[29:26]});
            tick();
        end

        // R4: trigger while busy ignored
        res_11b = 1'b1; twos_comp = 1'b0;
        trigger(8'h21);
        tick();
        trigger(8'h5E);
        check("R4 no start", conv_start, 1'b0);
        check("R4 conv_chan kept", conv_chan, 8'h21);
        rd(2'd0, d); check("R4 chan readback", d, 8'h21);
        tick();
        check("R4 no late start", conv_start, 1'b0);
        finish_done(11'h123);
        rd(2'd1, d); check("R4 R5 high after", d, 8'h01);
        rd(2'd2, d); check("R4 R5 low after", d, 8'h23);

        // R9: done while idle ignored
        tick();
        finish_done(11'h6EE);
        rd(2'd1, d); check("R9 high kept", d, 8'h01);
        rd(2'd2, d); check("R9 low kept", d, 8'h23);

        // R1: reset during a conversion
        trigger(8'h33);
        tick();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        rd(2'd1, d); check("R1 busy cleared by reset", d, 8'h00);
        rd(2'd0, d); check("R1 chan cleared by reset", d, 8'h00);
        rd(2'd2, d); check("R1 low cleared by reset", d, 8'h00);

        tick();
        summary();
    end

endmodule